// File: doc/BRIEF.md
# SD Command Line Serial Engine

This block owns the one-bit command wire of an SD card interface and runs on the card clock. On a request from the host side it captures a setting word and a command word (index and argument). It builds a 48-bit command frame with its own CRC7 and shifts that frame onto the line. Depending on the response type it then either waits out a fixed turnaround or listens for a 48-bit or 136-bit reply. For a reply it checks the reply's CRC7 if asked to, and makes the captured reply readable one 32-bit word at a time.

The requester works in another clock domain. Its request is passed through a two-stage synchronizer before the engine acts on it, and the request must stay high until acknowledge is seen. Acknowledge is the AND of two registered terms. The decode term is set when the request is accepted. The sequencer term is set only once the whole exchange, including turnaround, is over. A status word exposes the current state code and three result flags. After reset, the engine releases the line for a fixed preamble and then drives one high bit before it accepts any request.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset the state code (status[3:0]) is 0 and the line is released (cmd_oe_o low) for INIT_CYCLES (default 64) cycles. On the next cycle cmd_oe_o is high with cmd_out_o at 1 and the state code is still 0. After that the state code is 1 (idle) and never returns to 0.
- R2: The request passes a two-flop synchronizer. When req_i rises, the engine shows two more idle cycles, and then the first frame bit appears with state code 2.
- R3: The frame is 48 bits, sent MSB first, with cmd_oe_o high for exactly those 48 cycles. Its fields in order are: a 0 bit, a 1 bit, the index cmd_i[37:32], the argument cmd_i[31:0], a 7-bit CRC, and a 1 bit.
- R4: The frame CRC is the CRC7 with generator x^7 + x^3 + 1, starting from zero and computed over the first 40 frame bits.
- R5: Response type setting_i[1:0] = 00 expects no reply. After the end bit the engine spends exactly 8 cycles in state code 5 and then raises ack_o. The data-available flag stays 0.
- R6: Response type 01 captures a 136-bit reply and response types 10 and 11 capture a 48-bit reply. With any nonzero type the engine waits for the reply in state code 3.
- R7: If cmd_in_i shows no 0 start bit during timeout_i+1 waiting cycles, status[4] (timeout) is set, no reply is captured, and the engine goes on to the reply turnaround.
- R8: With setting_i[2] = 1, status[5] is 1 only when the received CRC7 equals the CRC7 of the reply's covered bits. These are the first 40 bits of a 48-bit reply, or bits 8 to 127 of a 136-bit reply counting from the start bit as bit 0. With setting_i[2] = 0, status[5] is 1 after any complete reply.
- R9: status[6] (data available) is set when the last reply bit is captured. status[6:4] all clear when the next request is accepted.
- R10: For a 136-bit reply, word_sel_i = k puts bits [32k+31:32k] of the reply on resp_o, where bit 0 is the end bit. For a 48-bit reply, resp_o is the 32-bit argument field whatever word_sel_i is.
- R11: After a reply or a timeout, the engine stays in state code 6 for D+1 cycles and then raises ack_o. D is setting_i[5:3], and a field of 0 means D = 7.
- R12: ack_o is high only in state code 7 and stays high while req_i is high. After req_i falls, ack_o stays high for two more cycles. It is low on the third cycle, with the state code back at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock, the engine's only clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request from the host domain, held until acknowledged |
| ack_o | output | 1 | Acknowledge: decode done AND sequence done |
| setting_i | input | 6 | [1:0] response type, [2] CRC check enable, [5:3] reply turnaround |
| cmd_i | input | 38 | [37:32] command index, [31:0] argument |
| timeout_i | input | CNT_W | Reply wait limit in cycles minus one |
| word_sel_i | input | 2 | Selects the 32-bit word of a long reply |
| resp_o | output | 32 | Selected word of the captured reply |
| status_o | output | 16 | [3:0] state code, [4] timeout, [5] CRC valid, [6] data available |
| cmd_out_o | output | 1 | Serial command bit towards the card |
| cmd_oe_o | output | 1 | Drive enable for the command line |
| cmd_in_i | input | 1 | Serial command line from the card |

## Verification
Commands are sent with all-zero, all-one and mixed index and argument values. These patterns separate a wrong bit order or field placement from a wrong CRC tap. Each reply kind is tried against each CRC setting: a good 48-bit reply with checking on, a corrupted reply with checking on and off, and a good 136-bit reply read back through all four word selections. These runs tell a capture-length error apart from a CRC-gating error and a word-slicing error. Several turnaround values, including the zero field, and a silent card that forces a timeout pin down the cycle counts of every waiting state.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int CMD_BITS  = 48;
    localparam int CMD_BODY  = 40;
    localparam int CMD_W     = 38;
    localparam int SET_W     = 6;
    localparam int DLY_W     = 3;
    localparam int CRC_W     = 7;
    localparam int RSP_SHORT = 48;
    localparam int RSP_LONG  = 136;
    localparam int LONG_HDR  = 8;
    localparam int BODY_W    = RSP_LONG - LONG_HDR;
    localparam int WORD_W    = 32;
    localparam int WSEL_W    = 2;
    localparam int STAT_W    = 16;

    typedef enum logic [3:0] {
        ST_INIT     = 4'd0,
        ST_IDLE     = 4'd1,
        ST_SEND     = 4'd2,
        ST_WAIT     = 4'd3,
        ST_RECV     = 4'd4,
        ST_TURN_NR  = 4'd5,
        ST_TURN_RSP = 4'd6,
        ST_ACK      = 4'd7
    } state_e;

endpackage

// File: rtl/sdcmd_sync.sv
module sdcmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[g] <= 1'b0;
                    else         chain_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[g] <= 1'b0;
                    else         chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdcmd_crc7_step.sv
module sdcmd_crc7_step #(
    parameter int             W    = 7,
    parameter logic [W-1:0]   POLY = 7'h09
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;
    assign fb    = bit_i ^ crc_i[W-1];
    assign crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
endmodule

// File: rtl/sdcmd_rsp_sel.sv
module sdcmd_rsp_sel #(
    parameter int BODY_W   = 128,
    parameter int WORD_W   = 32,
    parameter int SHORT_LO = 8
) (
    input  logic [BODY_W-1:0]         body_i,
    input  logic                      long_i,
    input  logic [$clog2(BODY_W/WORD_W)-1:0] sel_i,
    output logic [WORD_W-1:0]         word_o
);
    localparam int NWORDS = BODY_W / WORD_W;

    logic [WORD_W-1:0] words [NWORDS];

    genvar k;
    generate
        for (k = 0; k < NWORDS; k++) begin : g_word
            assign words[k] = body_i[k*WORD_W +: WORD_W];
        end
    endgenerate

    assign word_o = long_i ? words[sel_i] : body_i[SHORT_LO +: WORD_W];
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int INIT_CYCLES = 64,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int NR_TURN     = 8,
    parameter int DLY_DEFAULT = 7
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_i,
    output logic                ack_o,
    input  logic [SET_W-1:0]    setting_i,
    input  logic [CMD_W-1:0]    cmd_i,
    input  logic [CNT_W-1:0]    timeout_i,
    input  logic [WSEL_W-1:0]   word_sel_i,
    output logic [WORD_W-1:0]   resp_o,
    output logic [STAT_W-1:0]   status_o,
    output logic                cmd_out_o,
    output logic                cmd_oe_o,
    input  logic                cmd_in_i
);
    typedef struct packed {
        state_e              st;
        logic [CNT_W-1:0]    cnt;
        logic [CMD_BODY-1:0] sh;
        logic [CRC_W-1:0]    crc;
        logic [RSP_LONG-1:0] rsp;
        logic [1:0]          rtype;
        logic                crc_en;
        logic [DLY_W-1:0]    dly;
        logic                long_rsp;
        logic                dec_done;
        logic                fsm_done;
        logic                to_flag;
        logic                crc_ok;
        logic                avail;
    } regs_t;

    regs_t q, d;

    logic                req_s;
    logic                crc_bit;
    logic [CRC_W-1:0]    crc_nxt;
    logic [DLY_W-1:0]    eff_dly;
    logic [CNT_W-1:0]    last_bit;
    logic                feed;

    sdcmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (req_i),
        .q_o    (req_s)
    );

    assign crc_bit = (q.st == ST_SEND) ? q.sh[CMD_BODY-1] : cmd_in_i;

    sdcmd_crc7_step #(.W(CRC_W), .POLY(7'h09)) u_crc (
        .crc_i (q.crc),
        .bit_i (crc_bit),
        .crc_o (crc_nxt)
    );

    sdcmd_rsp_sel #(.BODY_W(BODY_W), .WORD_W(WORD_W), .SHORT_LO(LONG_HDR)) u_sel (
        .body_i (q.rsp[BODY_W-1:0]),
        .long_i (q.long_rsp),
        .sel_i  (word_sel_i),
        .word_o (resp_o)
    );

    assign eff_dly  = (q.dly == '0) ? DLY_W'(DLY_DEFAULT) : q.dly;
    assign last_bit = q.long_rsp ? CNT_W'(RSP_LONG - 1) : CNT_W'(RSP_SHORT - 1);
    assign feed     = q.long_rsp
                    ? (q.cnt >= CNT_W'(LONG_HDR) && q.cnt < CNT_W'(BODY_W))
                    : (q.cnt < CNT_W'(CMD_BODY));

    always_comb begin
        d = q;
        unique case (q.st)
            ST_INIT: begin
                if (q.cnt == CNT_W'(INIT_CYCLES)) begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_IDLE: begin
                if (req_s) begin
                    d.st       = ST_SEND;
                    d.cnt      = '0;
                    d.sh       = {1'b0, 1'b1, cmd_i};
                    d.crc      = '0;
                    d.rtype    = setting_i[1:0];
                    d.crc_en   = setting_i[2];
                    d.dly      = setting_i[5:3];
                    d.long_rsp = (setting_i[1:0] == 2'b01);
                    d.dec_done = 1'b1;
                    d.fsm_done = 1'b0;
                    d.to_flag  = 1'b0;
                    d.crc_ok   = 1'b0;
                    d.avail    = 1'b0;
                end
            end
            ST_SEND: begin
                if (q.cnt < CNT_W'(CMD_BODY)) begin
                    d.crc = crc_nxt;
                    d.sh  = {q.sh[CMD_BODY-2:0], 1'b0};
                end else if (q.cnt < CNT_W'(CMD_BITS - 1)) begin
                    d.crc = {q.crc[CRC_W-2:0], 1'b0};
                end
                if (q.cnt == CNT_W'(CMD_BITS - 1)) begin
                    d.cnt = '0;
                    d.st  = (q.rtype == 2'b00) ? ST_TURN_NR : ST_WAIT;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (!cmd_in_i) begin
                    d.st  = ST_RECV;
                    d.cnt = CNT_W'(1);
                    d.rsp = {q.rsp[RSP_LONG-2:0], 1'b0};
                    d.crc = '0;
                end else if (q.cnt == timeout_i) begin
                    d.st      = ST_TURN_RSP;
                    d.cnt     = '0;
                    d.to_flag = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RECV: begin
                d.rsp = {q.rsp[RSP_LONG-2:0], cmd_in_i};
                if (feed) d.crc = crc_nxt;
                if (q.cnt == last_bit) begin
                    d.crc_ok = !q.crc_en || (q.crc == q.rsp[CRC_W-1:0]);
                    d.avail  = 1'b1;
                    d.st     = ST_TURN_RSP;
                    d.cnt    = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_TURN_NR: begin
                if (q.cnt == CNT_W'(NR_TURN - 1)) begin
                    d.st       = ST_ACK;
                    d.fsm_done = 1'b1;
                    d.cnt      = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_TURN_RSP: begin
                if (q.cnt == CNT_W'(eff_dly)) begin
                    d.st       = ST_ACK;
                    d.fsm_done = 1'b1;
                    d.cnt      = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_ACK: begin
                if (!req_s) begin
                    d.st       = ST_IDLE;
                    d.dec_done = 1'b0;
                    d.fsm_done = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.st    <= ST_INIT;
        end else begin
            q <= d;
        end
    end

    assign ack_o    = q.dec_done & q.fsm_done;
    assign cmd_oe_o = (q.st == ST_SEND) ||
                      (q.st == ST_INIT && q.cnt == CNT_W'(INIT_CYCLES));

    always_comb begin
        cmd_out_o = 1'b1;
        if (q.st == ST_SEND) begin
            if (q.cnt < CNT_W'(CMD_BODY))           cmd_out_o = q.sh[CMD_BODY-1];
            else if (q.cnt < CNT_W'(CMD_BITS - 1))  cmd_out_o = q.crc[CRC_W-1];
        end
    end

    assign status_o = {{(STAT_W-7){1'b0}}, q.avail, q.crc_ok, q.to_flag, q.st};
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       ack_o,
    input logic       cmd_oe_o,
    input logic       cmd_out_o,
    input logic [6:0] status_i
);
    logic [3:0] st;
    assign st = status_i[3:0];

    // R12
    ack_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> st == 4'd7);

    // R3
    oe_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_oe_o |-> (st == 4'd2 || st == 4'd0));

    // R3
    start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == 4'd2 && $past(st) != 4'd2) |-> (!cmd_out_o && cmd_oe_o));

    // R3
    end_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st != 4'd2 && $past(st) == 4'd2) |-> $past(cmd_out_o));

    // R1
    init_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(st) != 4'd0) |-> st != 4'd0);

    // R11
    ack_after_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ack_o) |-> ($past(st) == 4'd5 || $past(st) == 4'd6));

    // R7
    timeout_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_i[4] |-> (!status_i[5] && !status_i[6]));
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_o     (ack_o),
    .cmd_oe_o  (cmd_oe_o),
    .cmd_out_o (cmd_out_o),
    .status_i  (status_o[6:0])
);

// File: tb/tb_sdcmd_engine.sv
`timescale 1ns/1ps
module tb_sdcmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        ack;
    logic [5:0]  setting = '0;
    logic [37:0] cmd = '0;
    logic [15:0] timeout = '0;
    logic [1:0]  word_sel = '0;
    logic [31:0] resp;
    logic [15:0] status;
    logic        cmd_out, cmd_oe;
    logic        cmd_in = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdcmd_engine dut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_o(ack),
        .setting_i(setting), .cmd_i(cmd), .timeout_i(timeout),
        .word_sel_i(word_sel), .resp_o(resp), .status_o(status),
        .cmd_out_o(cmd_out), .cmd_oe_o(cmd_oe), .cmd_in_i(cmd_in)
    );

    task automatic chk(input bit ok, input string req_tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [127:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [135:0] frame48(input logic [5:0] idx, input logic [31:0] arg, input bit bad);
        logic [39:0] body = {2'b00, idx, arg};
        logic [6:0]  c    = ref_crc({88'd0, body}, 40) ^ (bad ? 7'h01 : 7'h00);
        return {88'd0, body, c, 1'b1};
    endfunction

    function automatic logic [135:0] frame136(input logic [119:0] content, input bit bad);
        logic [6:0] c = ref_crc({8'd0, content}, 120) ^ (bad ? 7'h01 : 7'h00);
        return {2'b00, 6'h3f, content, c, 1'b1};
    endfunction

    // raise request, measure sync latency, capture and check the frame (R2 R3 R4 R9)
    task automatic send_cmd(input logic [5:0] set, input logic [5:0] idx,
                            input logic [31:0] arg, input logic [15:0] to);
        int pre = 0;
        bit oe_ok = 1'b1;
        logic [47:0] frm;
        logic [39:0] body = {1'b0, 1'b1, idx, arg};
        setting = set; cmd = {idx, arg}; timeout = to; req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (cmd_oe) break;
            pre++;
        end
        chk(pre == 2, "R2", "idle cycles before start bit", pre, 2);
        chk(status[3:0] == 4'd2, "R2", "send state code", status[3:0], 2);
        chk(status[6:4] == 3'b000, "R9", "flags cleared on request", status[6:4], 0);
        for (int i = 0; i < 48; i++) begin
            if (!cmd_oe) oe_ok = 1'b0;
            frm[47 - i] = cmd_out;
            @(negedge clk);
        end
        chk(oe_ok && !cmd_oe, "R3", "drive window of 48 cycles", cmd_oe, 0);
        chk(frm[47:8] == body && frm[0] == 1'b1, "R3", "frame fields", frm, {body, 7'd0, 1'b1});
        chk(frm[7:1] == ref_crc({88'd0, body}, 40), "R4", "frame crc7", frm[7:1], ref_crc({88'd0, body}, 40));
    endtask

    task automatic card_reply(input logic [135:0] f, input int len);
        repeat (2) @(negedge clk);
        for (int i = len - 1; i >= 0; i--) begin
            cmd_in = f[i];
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic wait_ack(input int exp_n, input logic [3:0] code, input string req_tag);
        int n = 0;
        bit code_ok = 1'b1;
        while (!ack && n < 400) begin
            if (status[3:0] != code) code_ok = 1'b0;
            n++;
            @(negedge clk);
        end
        chk(n == exp_n, req_tag, "turnaround length", n, exp_n);
        chk(code_ok, req_tag, "turnaround state code", status[3:0], code);
    endtask

    task automatic release_req();
        logic a1, a2, a3;
        repeat (4) @(negedge clk);
        chk(ack == 1'b1, "R12", "ack held while request high", ack, 1);
        req = 1'b0;
        @(negedge clk); a1 = ack;
        @(negedge clk); a2 = ack;
        @(negedge clk); a3 = ack;
        chk(a1 && a2 && !a3 && status[3:0] == 4'd1, "R12", "ack release timing",
            {a1, a2, a3, status[3:0]}, {3'b110, 4'd1});
        @(negedge clk);
    endtask

    task automatic t_reset_init();
        int n = 0;
        repeat (3) @(negedge clk);
        chk(status[3:0] == 4'd0 && !cmd_oe && !ack, "R1", "reset state",
            {status[3:0], cmd_oe, ack}, 0);
        rst_n = 1'b1;
        while (status[3:0] == 4'd0 && !cmd_oe && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk(n == 64, "R1", "released preamble length", n, 64);
        chk(cmd_oe && cmd_out && status[3:0] == 4'd0, "R1", "preamble high bit",
            {cmd_oe, cmd_out, status[3:0]}, {2'b11, 4'd0});
        @(negedge clk);
        chk(status[3:0] == 4'd1 && !cmd_oe, "R1", "idle after preamble", status[3:0], 1);
    endtask

    task automatic t_no_response(input logic [5:0] idx, input logic [31:0] arg);
        send_cmd(6'b000_0_00, idx, arg, 16'd50);
        wait_ack(8, 4'd5, "R5");
        chk(status[6] == 1'b0, "R5", "nothing captured", status[6], 0);
        release_req();
    endtask

    task automatic t_short_good();
        logic [135:0] f = frame48(6'h11, 32'hCAFE_F00D, 1'b0);
        send_cmd({3'd3, 1'b1, 2'b10}, 6'h11, 32'h0000_0900, 16'd100);
        chk(status[3:0] == 4'd3, "R6", "waiting for reply", status[3:0], 3);
        card_reply(f, 48);
        wait_ack(4, 4'd6, "R11");
        chk(status[5] == 1'b1, "R8", "good crc reported valid", status[5], 1);
        chk(status[6] == 1'b1 && status[4] == 1'b0, "R9", "data available", status[6:4], 3'b110);
        word_sel = 2'd0; #1;
        chk(resp == 32'hCAFE_F00D, "R10", "short reply word sel 0", resp, 32'hCAFE_F00D);
        word_sel = 2'd3; #1;
        chk(resp == 32'hCAFE_F00D, "R10", "short reply word sel 3", resp, 32'hCAFE_F00D);
        release_req();
    endtask

    task automatic t_short_bad(input bit check_on, input logic [1:0] rt,
                               input logic [2:0] dly, input int exp_turn);
        logic [135:0] f = frame48(6'h2a, 32'h1234_5678, 1'b1);
        send_cmd({dly, check_on, rt}, 6'h3f, 32'hFFFF_FFFF, 16'd100);
        chk(status[3:0] == 4'd3, "R6", "waiting for reply", status[3:0], 3);
        card_reply(f, 48);
        wait_ack(exp_turn, 4'd6, "R11");
        chk(status[5] == !check_on, "R8", "crc valid with bad crc", status[5], !check_on);
        chk(status[6] == 1'b1, "R6", "48-bit reply captured", status[6], 1);
        chk(resp == 32'h1234_5678, "R10", "short reply argument", resp, 32'h1234_5678);
        release_req();
    endtask

    task automatic t_long();
        logic [135:0] f = frame136(120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32, 1'b0);
        send_cmd({3'd5, 1'b1, 2'b01}, 6'h02, 32'hA5A5_5A5A, 16'd100);
        card_reply(f, 136);
        wait_ack(6, 4'd6, "R11");
        chk(status[5] == 1'b1 && status[6] == 1'b1, "R6", "136-bit reply crc and capture",
            status[6:5], 2'b11);
        for (int k = 0; k < 4; k++) begin
            word_sel = 2'(k); #1;
            chk(resp == f[32*k +: 32], "R10", "long reply word", resp, f[32*k +: 32]);
        end
        word_sel = 2'd0;
        release_req();
    endtask

    task automatic t_timeout();
        int n = 0;
        send_cmd({3'd2, 1'b1, 2'b10}, 6'h0c, 32'h0F0F_F0F0, 16'd20);
        while (status[3:0] == 4'd3 && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == 21, "R7", "wait cycles before timeout", n, 21);
        wait_ack(3, 4'd6, "R11");
        chk(status[4] == 1'b1 && status[6] == 1'b0, "R7", "timeout flag, no data",
            status[6:4], 3'b001);
        release_req();
    endtask

    initial begin
        t_reset_init();
        t_no_response(6'h00, 32'h0000_0000);
        t_no_response(6'h3f, 32'hFFFF_FFFF);
        t_no_response(6'h11, 32'h1234_5678);
        t_short_good();
        t_short_bad(1'b1, 2'b11, 3'd0, 8);
        t_short_bad(1'b0, 2'b10, 3'd1, 2);
        t_long();
        t_timeout();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hang, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule